// File: doc/BRIEF.md
# GPIO Bank with Latched-Level Interrupts

This block is a bank of general-purpose I/O pins behind a simple synchronous register port. Software drives pin values and per-pin output enables, samples the pins through a two-flop synchroniser, and selects an alternate function for fixed groups of pins. The first twelve pins also act as level-sensitive interrupt sources. Each source has its own polarity field, its own enable bit and a latched status bit that software clears by writing a one. Status bits that are both latched and enabled are ORed onto a single shared interrupt line.

Each interrupt line is a two-state machine. In `LINE_IDLE` the status bit reads 0. The transition *arm* moves it to `LINE_LATCHED` in the first cycle its synchronised source is at the active level. In `LINE_LATCHED` the status bit reads 1. The transition *release* returns it to `LINE_IDLE` only when software writes a one to that status bit while the source is inactive. If a clear meets an active source, the line stays in `LINE_LATCHED`, so a level that is still asserted is never lost.

Register word addresses are as follows. 0 is pin input (read-only). 1 is output value. 2 is output enable. 3 is interrupt enable. 4 is interrupt status (write one to clear). 5 is the low type register. 6 is the high type register. 7 is the mux control register. Any other address reads 0.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, `pins_out`, `pins_oe`, `alt_sel` and `irq_out` are 0, and a read of an address from 8 to 15 returns 0.
- R2: A write to address 1 or 2 updates `pins_out` or `pins_oe` on that clock edge, and the value reads back. An enable bit of 1 drives the pin and 0 leaves it an input.
- R3: Address 0 returns the pin levels after a two-flop synchroniser. Read data for any address appears on `bus_rdata` one cycle after the read strobe and holds until the next read.
- R4: Line i (0 to 11) takes its source from pin i and uses the 4-bit type field at bits 4*(i mod 8). Lines 0 to 7 use address 5 and lines 8 to 11 use address 6. Field value 1 means active-low and every other value means active-high. A status bit latches whenever its source is active, whatever its enable bit holds.
- R5: Writing status (address 4) with a 1 in a bit clears that bit when its source is inactive. A 0 bit leaves the status unchanged. Writing 0xFFF clears every inactive line.
- R6: If a clear hits a status bit whose source is still active, the bit stays set.
- R7: `irq_out` is 1 exactly when some line has both its status and enable (address 3) bits set. A pin reaching the active level raises `irq_out` after the third rising edge.
- R8: Mux control bit 0 selects the function of pins 0–5, bit 1 pins 6–7, bit 2 pins 8–11, bit 3 pins 15–16, bit 4 pins 17–19, bit 5 pin 20 and bit 6 pin 21. The value appears on `alt_sel` for those pins. Pins 12–14 always show 0.
- R9: Writes to address 0 have no effect. Bits of address 6 above bit 15 and bits of address 7 above bit 6 are not stored and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pins_in | input | 22 | Raw pin levels |
| pins_out | output | 22 | Driven pin values |
| pins_oe | output | 22 | Per-pin output enable |
| alt_sel | output | 22 | Per-pin function select |
| irq_out | output | 1 | Shared interrupt |

## Verification
Register writes take effect on the edge of the strobe cycle, so output pins and `alt_sel` are sampled on the falling edge that follows. Read data is registered, so each read task samples `bus_rdata` on the falling edge after the edge that consumed the strobe. A pin change passes two synchroniser flops and then the line state register. The bench changes the pin on a falling edge, expects `irq_out` still low after the second rising edge, and expects it high after the third. Enable changes reach `irq_out` on the same edge as their write, because the output is a combinational OR of two registers.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [3:0] {
        ADR_PIN_IN   = 4'd0,
        ADR_OUT_VAL  = 4'd1,
        ADR_OUT_EN   = 4'd2,
        ADR_IRQ_EN   = 4'd3,
        ADR_IRQ_STAT = 4'd4,
        ADR_TYPE_LO  = 4'd5,
        ADR_TYPE_HI  = 4'd6,
        ADR_MUX      = 4'd7
    } reg_addr_e;

    typedef enum logic {
        LINE_IDLE    = 1'b0,
        LINE_LATCHED = 1'b1
    } line_state_e;

    localparam logic [3:0] TYPE_ACT_LOW = 4'd1;

    // Mux group that owns a pin, or -1 if the pin has no group.
    function automatic int mux_group(input int pin);
        if (pin >= 0 && pin <= 5)   return 0;
        if (pin >= 6 && pin <= 7)   return 1;
        if (pin >= 8 && pin <= 11)  return 2;
        if (pin >= 15 && pin <= 16) return 3;
        if (pin >= 17 && pin <= 19) return 4;
        if (pin == 20)              return 5;
        if (pin == 21)              return 6;
        return -1;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= raw_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  logic [3:0] type_fld,
    input  logic       clr,
    output logic       status
);

    line_state_e state_q;
    line_state_e state_d;
    logic        src_act;

    assign src_act = pin_s ^ (type_fld == TYPE_ACT_LOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:    if (src_act)         state_d = LINE_LATCHED;
            LINE_LATCHED: if (clr && !src_act) state_d = LINE_IDLE;
            default:                           state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        status = (state_q == LINE_LATCHED);
    end

    // R6: an active source wins over a simultaneous clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && src_act) |=> status);

    // R5: clear of an inactive source drops the bit
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (status && clr && !src_act) |=> !status);

    // R5: without a clear a latched bit holds
    a_r5_hold_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);

    // R4: an active source latches regardless of enable
    a_r4_latch_on_active: assert property (@(posedge clk) disable iff (!rst_n)
        src_act |=> status);

endmodule

// File: rtl/gpio_mux_map.sv
module gpio_mux_map
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 22,
    parameter int NMUX  = 7
) (
    input  logic [NMUX-1:0]  mux_sel,
    output logic [NPINS-1:0] alt_sel
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int GRP = mux_group(p);
        if (GRP >= 0 && GRP < NMUX) begin : g_mapped
            assign alt_sel[p] = mux_sel[GRP];
        end else begin : g_fixed
            assign alt_sel[p] = 1'b0;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 22,
    parameter int NIRQ  = 12,
    parameter int NMUX  = 7,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [3:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pins_in,
    output logic [NPINS-1:0] pins_out,
    output logic [NPINS-1:0] pins_oe,
    output logic [NPINS-1:0] alt_sel,
    output logic             irq_out
);

    localparam int TW   = NIRQ * 4;
    localparam int HI_W = TW - 32;

    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] oe_q;
    logic [NIRQ-1:0]  en_q;
    logic [TW-1:0]    type_q;
    logic [NMUX-1:0]  mux_q;
    logic [DW-1:0]    rdata_q;
    logic [DW-1:0]    rd_word;
    logic [NPINS-1:0] pin_s;
    logic [NIRQ-1:0]  stat;
    logic [NIRQ-1:0]  clr_mask;

    gpio_sync #(.WIDTH(NPINS)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pins_in),
        .sync_out (pin_s)
    );

    assign clr_mask = (bus_wr && bus_addr == ADR_IRQ_STAT) ? bus_wdata[NIRQ-1:0] : '0;

    for (genvar i = 0; i < NIRQ; i++) begin : g_line
        gpio_irq_line i_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_s    (pin_s[i]),
            .type_fld (type_q[4*i +: 4]),
            .clr      (clr_mask[i]),
            .status   (stat[i])
        );
    end

    gpio_mux_map #(.NPINS(NPINS), .NMUX(NMUX)) i_mux (
        .mux_sel (mux_q),
        .alt_sel (alt_sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            oe_q   <= '0;
            en_q   <= '0;
            type_q <= '0;
            mux_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADR_OUT_VAL: out_q          <= bus_wdata[NPINS-1:0];
                ADR_OUT_EN:  oe_q           <= bus_wdata[NPINS-1:0];
                ADR_IRQ_EN:  en_q           <= bus_wdata[NIRQ-1:0];
                ADR_TYPE_LO: type_q[31:0]   <= bus_wdata[31:0];
                ADR_TYPE_HI: type_q[TW-1:32] <= bus_wdata[HI_W-1:0];
                ADR_MUX:     mux_q          <= bus_wdata[NMUX-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            ADR_PIN_IN:   rd_word[NPINS-1:0] = pin_s;
            ADR_OUT_VAL:  rd_word[NPINS-1:0] = out_q;
            ADR_OUT_EN:   rd_word[NPINS-1:0] = oe_q;
            ADR_IRQ_EN:   rd_word[NIRQ-1:0]  = en_q;
            ADR_IRQ_STAT: rd_word[NIRQ-1:0]  = stat;
            ADR_TYPE_LO:  rd_word[31:0]      = type_q[31:0];
            ADR_TYPE_HI:  rd_word[HI_W-1:0]  = type_q[TW-1:32];
            ADR_MUX:      rd_word[NMUX-1:0]  = mux_q;
            default:      rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;
    assign pins_out  = out_q;
    assign pins_oe   = oe_q;
    assign irq_out   = |(stat & en_q);

    // R2: output enable follows its write on the next cycle
    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_OUT_EN) |=> (pins_oe == $past(bus_wdata[NPINS-1:0])));

    // R3: read data holds between reads
    a_r3_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R7: the shared interrupt always has a latched source behind it
    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ($countones(stat) > 0));

endmodule

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;

    localparam int NP = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pins_in = '0;
    logic [NP-1:0] pins_out;
    logic [NP-1:0] pins_oe;
    logic [NP-1:0] alt_sel;
    logic          irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_in   (pins_in),
        .pins_out  (pins_out),
        .pins_oe   (pins_oe),
        .alt_sel   (alt_sel),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic [NP-1:0] alt_expect(input logic [6:0] m);
        logic [NP-1:0] r = '0;
        for (int p = 0; p < NP; p++) begin
            if (p == 21)                 r[p] = m[6];
            else if (p == 20)            r[p] = m[5];
            else if (p >= 17 && p <= 19) r[p] = m[4];
            else if (p == 15 || p == 16) r[p] = m[3];
            else if (p >= 8 && p <= 11)  r[p] = m[2];
            else if (p == 6 || p == 7)   r[p] = m[1];
            else if (p <= 5)             r[p] = m[0];
        end
        return r;
    endfunction

    task automatic t_reset;
        for (int a = 0; a < 16; a++) begin
            rd_reg(4'(a), rd);
            chk("R1 register reset value", rd, 32'h0);
        end
        chk("R1 pins_out reset", 32'(pins_out), 32'h0);
        chk("R1 pins_oe reset", 32'(pins_oe), 32'h0);
        chk("R1 alt_sel reset", 32'(alt_sel), 32'h0);
        chk("R1 irq_out reset", 32'(irq_out), 32'h0);
    endtask

    task automatic t_outputs;
        wr_reg(4'd1, 32'hFF2A_5A5A);
        chk("R2 pins_out after write", 32'(pins_out), 32'h002A_5A5A);
        wr_reg(4'd2, 32'h0015_5555);
        chk("R2 pins_oe after write", 32'(pins_oe), 32'h0015_5555);
        rd_reg(4'd1, rd);
        chk("R2 out value readback", rd, 32'h002A_5A5A);
        rd_reg(4'd2, rd);
        chk("R2 out enable readback", rd, 32'h0015_5555);
    endtask

    task automatic t_input;
        @(negedge clk);
        pins_in = 22'h2C_3A5C;
        idle(3);
        rd_reg(4'd0, rd);
        chk("R3 pin input readback", rd, 32'h002C_3A5C);
        wr_reg(4'd0, 32'h0);
        rd_reg(4'd0, rd);
        chk("R9 pin input ignores write", rd, 32'h002C_3A5C);
        pins_in = '0;
        idle(3);
        wr_reg(4'd4, 32'h0000_0FFF);
        rd_reg(4'd4, rd);
        chk("R5 clear all with 0xFFF", rd, 32'h0);
    endtask

    task automatic t_level_high;
        wr_reg(4'd3, 32'h0000_0008);
        @(negedge clk);
        pins_in[3] = 1'b1;
        idle(2);
        chk("R7 irq_out low after two edges", 32'(irq_out), 32'h0);
        idle(1);
        chk("R7 irq_out high after third edge", 32'(irq_out), 32'h1);
        rd_reg(4'd4, rd);
        chk("R4 active-high status latched", rd, 32'h0000_0008);
        wr_reg(4'd4, 32'h0000_0008);
        rd_reg(4'd4, rd);
        chk("R6 clear while active keeps bit", rd, 32'h0000_0008);
        chk("R6 irq_out stays high", 32'(irq_out), 32'h1);
        pins_in[3] = 1'b0;
        idle(3);
        wr_reg(4'd4, 32'h0000_0000);
        rd_reg(4'd4, rd);
        chk("R5 writing zero leaves status", rd, 32'h0000_0008);
        wr_reg(4'd4, 32'h0000_0008);
        rd_reg(4'd4, rd);
        chk("R5 clear inactive line", rd, 32'h0);
        chk("R7 irq_out low after clear", 32'(irq_out), 32'h0);
    endtask

    task automatic t_polarity;
        pins_in[5] = 1'b1;
        wr_reg(4'd5, 32'h0010_0000);
        idle(3);
        rd_reg(4'd4, rd);
        chk("R4 line 5 active-low idle when pin high", rd, 32'h0);
        pins_in[5] = 1'b0;
        idle(3);
        rd_reg(4'd4, rd);
        chk("R4 line 5 latches low though disabled", rd, 32'h0000_0020);
        chk("R7 disabled line keeps irq_out low", 32'(irq_out), 32'h0);
        wr_reg(4'd6, 32'hFFFF_0210);
        rd_reg(4'd6, rd);
        chk("R9 high type register upper bits", rd, 32'h0000_0210);
        idle(3);
        rd_reg(4'd4, rd);
        chk("R4 line 9 active-low from high register", rd, 32'h0000_0220);
        pins_in[9]  = 1'b1;
        pins_in[5]  = 1'b1;
        idle(3);
        wr_reg(4'd4, 32'h0000_0FFF);
        rd_reg(4'd4, rd);
        chk("R5 clear after sources go inactive", rd, 32'h0);
        pins_in[10] = 1'b1;
        idle(3);
        rd_reg(4'd4, rd);
        chk("R4 field value 2 acts active-high", rd, 32'h0000_0400);
        wr_reg(4'd3, 32'h0000_0001);
        chk("R7 other line enabled, irq_out low", 32'(irq_out), 32'h0);
        wr_reg(4'd3, 32'h0000_0400);
        chk("R7 enabling pending line raises irq_out", 32'(irq_out), 32'h1);
        pins_in = '0;
        wr_reg(4'd5, 32'h0);
        wr_reg(4'd6, 32'h0);
        wr_reg(4'd3, 32'h0);
        idle(3);
        wr_reg(4'd4, 32'h0000_0FFF);
        rd_reg(4'd4, rd);
        chk("R5 final clear", rd, 32'h0);
    endtask

    task automatic t_mux;
        wr_reg(4'd7, 32'h0000_0055);
        chk("R8 alt_sel for 0x55", 32'(alt_sel), 32'(alt_expect(7'h55)));
        wr_reg(4'd7, 32'h0000_00FF);
        chk("R8 alt_sel all groups, pins 12-14 zero", 32'(alt_sel), 32'(alt_expect(7'h7F)));
        rd_reg(4'd7, rd);
        chk("R9 mux control upper bits", rd, 32'h0000_007F);
        wr_reg(4'd7, 32'h0000_0022);
        chk("R8 alt_sel for 0x22", 32'(alt_sel), 32'(alt_expect(7'h22)));
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset;
        t_outputs;
        t_input;
        t_level_high;
        t_polarity;
        t_mux;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule